// File: doc/BRIEF.md
# Pulse-and-Verify Array Programming Sequencer

This controller sits in programming equipment and writes a contiguous range of a word-organised one-time or erasable non-volatile array. After a start command it sets the program supply level, then works through the range one address at a time. For each word it asks a data source for the intended value, drives it onto the target data bus, fires an active-low chip-enable program pulse, releases the bus and reads the word back with output enable low. A word that reads back correctly is finished at once. A word that does not match gets another pulse, up to a fixed ceiling. When every word has been written, the whole range is read twice, first at a high verify supply level and then at a low one, to confirm that every cell has enough margin.

All timing windows are given in microseconds and turned into clock cycles by a cycles-per-microsecond parameter. The read-back delay is a plain cycle count. The state machine has ten states:

- `ST_IDLE`: waits for start.
- `ST_POWER`: supply settles.
- `ST_FETCH`: takes the word from the source.
- `ST_SETUP`: data driven before the pulse.
- `ST_PULSE`: program pulse.
- `ST_HOLD`: data held after the pulse.
- `ST_TURN`: bus released before reading.
- `ST_VERIFY`: per-word read-back.
- `ST_CSET`: address settle in the final check.
- `ST_CREAD`: final-check read.

The transitions are:

- start: IDLE→POWER.
- supply settled: POWER→FETCH.
- always: FETCH→SETUP.
- timer expiry: SETUP→PULSE→HOLD→TURN→VERIFY.
- match on a middle word: VERIFY→FETCH, next address.
- mismatch below the ceiling: VERIFY→FETCH, same address, count incremented.
- mismatch at the ceiling: VERIFY→IDLE with fail.
- match on the last word: VERIFY→CSET.
- always: CSET→CREAD.
- match on a middle word: CREAD→CSET.
- match on the last word of the high pass: CREAD→CSET, starting the low pass.
- match on the last word of the low pass: CREAD→IDLE with done.
- any mismatch: CREAD→IDLE with fail.

Top module: `word_burn_seq`

## Requirements
- R1: After reset the chip enable and output enable are high (inactive), the data bus is not driven, the supply select is 0 (off), and busy, done and fail are 0.
- R2: A start is taken only when busy is 0. It latches the first and last address (an inclusive, ascending range), and busy rises on the next clock. A start raised while busy is 1 changes neither the range nor the result.
- R3: The supply select reads 1 (program level) for at least 2 µs (2×CLK_PER_US cycles) before the address bus moves to the first address.
- R4: Before each pulse, the address and data are driven with output enable high for at least 2 µs. Each chip-enable low pulse lasts exactly PULSE_US µs (50 by default, inside the 45 to 55 µs window). The data stays driven for at least 2 µs after chip enable rises.
- R5: For verify, the data bus is released at least 2 µs before output enable falls. Output enable is never low while the bus is driven. The read-back is compared after RD_DLY cycles with output enable low.
- R6: When the per-word verify matches, the sequencer moves to the next address without any further pulse, so a word that needs k pulses receives exactly k.
- R7: On a mismatch the pulse counter (cleared for every new address) is incremented and another pulse follows. A word whose 25th (MAX_PULSES) pulse still fails to verify ends the run with fail and no further pulse.
- R8: After the last word, every word from first to last is read with the bus released, first at supply select 2 (high verify) and then at supply select 3 (low verify), comparing against the source. The first mismatch ends the run with fail.
- R9: The supply select encoding is 0 off, 1 program, 2 high verify, 3 low verify. Chip enable is low only at 1, and the select is 0 whenever busy is 0.
- R10: Done rises when a run ends, whether it passes or fails. Fail marks a failed run, and the failing address is latched at that moment. Done, fail and the address hold until the next accepted start, which clears done and fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| first_addr_i | input | ADDR_W | First address of the range |
| last_addr_i | input | ADDR_W | Last address of the range (inclusive) |
| src_addr_o | output | ADDR_W | Address whose intended word the source returns |
| src_data_i | input | DATA_W | Intended word for src_addr_o (combinational source) |
| tgt_addr_o | output | ADDR_W | Target address bus |
| tgt_wdata_o | output | DATA_W | Target data-in value |
| tgt_wdata_en_o | output | 1 | Data bus drive enable |
| tgt_rdata_i | input | DATA_W | Target read-back data |
| tgt_ce_n_o | output | 1 | Active-low chip enable (program pulse) |
| tgt_oe_n_o | output | 1 | Active-low output enable |
| supply_sel_o | output | 2 | Supply level: 0 off, 1 program, 2 high verify, 3 low verify |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (sticky) |
| fail_o | output | 1 | Run failed (sticky) |
| fail_addr_o | output | ADDR_W | Address at which the run failed |

## Verification
The target is modelled as an array of all-ones words that clears bits only after a set number of pulses per address. Some addresses can be made weak so that they read back wrong at one or both verify supply levels. The runs are chosen to tell apart distinct outcomes:

- One pulse per word separates the basic flow.
- Several pulses on a single-word range separate the retry loop from address advance.
- A word that needs exactly the ceiling separates an off-by-one ceiling from a correct one.
- A word that needs one more pulse than the ceiling shows both the fail path and the latched address.
- Weak cells seen only at the low level, or at both levels, show the ordering of the two final passes.

A timing monitor measures the setup, pulse-width, hold, bus-turnaround and power-up windows on every pulse. Counters of reads at each supply level expose any missing, extra or misordered pass.

// File: rtl/burn_pkg.sv
package burn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POWER,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_TURN,
        ST_VERIFY,
        ST_CSET,
        ST_CREAD
    } burn_state_e;

    typedef enum logic [1:0] {
        SUP_OFF  = 2'd0,
        SUP_PROG = 2'd1,
        SUP_VHI  = 2'd2,
        SUP_VLO  = 2'd3
    } supply_e;

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    // Loading len makes the owning state last exactly len cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (len_i != '0));

endmodule

// File: rtl/burn_retry.sv
module burn_retry #(
    parameter int MAX_PULSES = 25,
    parameter int W          = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    // A failing verify with this many earlier misses used up the ceiling.
    assign last_o = (cnt_q == W'(MAX_PULSES - 1));

    // R7
    retry_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(MAX_PULSES));

    // R7
    no_inc_at_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |-> !last_o);

endmodule

// File: rtl/word_burn_seq.sv
module word_burn_seq
    import burn_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CLK_PER_US = 4,
    parameter int PULSE_US   = 50,
    parameter int SETUP_US   = 2,
    parameter int HOLD_US    = 2,
    parameter int MAX_PULSES = 25,
    parameter int RD_DLY     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] first_addr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [DATA_W-1:0] tgt_wdata_o,
    output logic              tgt_wdata_en_o,
    input  logic [DATA_W-1:0] tgt_rdata_i,
    output logic              tgt_ce_n_o,
    output logic              tgt_oe_n_o,
    output logic [1:0]        supply_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o
);

    localparam int SET_CYC   = SETUP_US * CLK_PER_US;
    localparam int PULSE_CYC = PULSE_US * CLK_PER_US;
    localparam int HOLD_CYC  = HOLD_US * CLK_PER_US;
    localparam int TW        = $clog2(PULSE_CYC + SET_CYC + HOLD_CYC + RD_DLY + 2);
    localparam int RW        = $clog2(MAX_PULSES + 1);

    burn_state_e state_q, state_d;

    logic [ADDR_W-1:0] first_q, last_q, addr_q, fail_addr_q;
    logic [DATA_W-1:0] din_q;
    logic              pass2_q, done_q, fail_q;

    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_len;
    logic          r_clr, r_inc, r_last;
    logic [RW-1:0] r_cnt;

    logic accept, a_first, a_next, lat_din, set_pass2, fin_ok, fin_fail;
    logic last_hit;

    burn_timer #(.W(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_exp)
    );

    burn_retry #(.MAX_PULSES(MAX_PULSES), .W(RW)) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (r_clr),
        .inc_i  (r_inc),
        .cnt_o  (r_cnt),
        .last_o (r_last)
    );

    assign last_hit = (addr_q == last_q);

    // Next state, timer loads and datapath actions
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        r_clr     = 1'b0;
        r_inc     = 1'b0;
        accept    = 1'b0;
        a_first   = 1'b0;
        a_next    = 1'b0;
        lat_din   = 1'b0;
        set_pass2 = 1'b0;
        fin_ok    = 1'b0;
        fin_fail  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept   = 1'b1;
                    state_d  = ST_POWER;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(SET_CYC);
                end
            end
            ST_POWER: begin
                if (tmr_exp) begin
                    state_d = ST_FETCH;
                    a_first = 1'b1;
                    r_clr   = 1'b1;
                end
            end
            ST_FETCH: begin
                state_d  = ST_SETUP;
                lat_din  = 1'b1;
                tmr_load = 1'b1;
                tmr_len  = TW'(SET_CYC);
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(PULSE_CYC);
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(HOLD_CYC);
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(SET_CYC);
                end
            end
            ST_TURN: begin
                if (tmr_exp) begin
                    state_d  = ST_VERIFY;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(RD_DLY);
                end
            end
            ST_VERIFY: begin
                if (tmr_exp) begin
                    if (tgt_rdata_i == din_q) begin
                        if (last_hit) begin
                            state_d  = ST_CSET;
                            a_first  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_len  = TW'(SET_CYC);
                        end else begin
                            state_d = ST_FETCH;
                            a_next  = 1'b1;
                            r_clr   = 1'b1;
                        end
                    end else if (r_last) begin
                        state_d  = ST_IDLE;
                        fin_fail = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                        r_inc   = 1'b1;
                    end
                end
            end
            ST_CSET: begin
                if (tmr_exp) begin
                    state_d  = ST_CREAD;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(RD_DLY);
                end
            end
            ST_CREAD: begin
                if (tmr_exp) begin
                    if (tgt_rdata_i != src_data_i) begin
                        state_d  = ST_IDLE;
                        fin_fail = 1'b1;
                    end else if (last_hit && pass2_q) begin
                        state_d = ST_IDLE;
                        fin_ok  = 1'b1;
                    end else begin
                        state_d   = ST_CSET;
                        tmr_load  = 1'b1;
                        tmr_len   = TW'(SET_CYC);
                        a_first   = last_hit;
                        set_pass2 = last_hit;
                        a_next    = !last_hit;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= '0;
            last_q      <= '0;
            addr_q      <= '0;
            din_q       <= '0;
            fail_addr_q <= '0;
            pass2_q     <= 1'b0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            if (accept) begin
                first_q <= first_addr_i;
                last_q  <= last_addr_i;
                pass2_q <= 1'b0;
                done_q  <= 1'b0;
                fail_q  <= 1'b0;
            end
            if (a_first) begin
                addr_q <= first_q;
            end else if (a_next) begin
                addr_q <= addr_q + 1'b1;
            end
            if (lat_din) begin
                din_q <= src_data_i;
            end
            if (set_pass2) begin
                pass2_q <= 1'b1;
            end
            if (fin_ok) begin
                done_q <= 1'b1;
            end
            if (fin_fail) begin
                done_q      <= 1'b1;
                fail_q      <= 1'b1;
                fail_addr_q <= addr_q;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        tgt_ce_n_o     = 1'b1;
        tgt_oe_n_o     = 1'b1;
        tgt_wdata_en_o = 1'b0;
        supply_sel_o   = SUP_OFF;
        busy_o         = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_POWER:  supply_sel_o = SUP_PROG;
            ST_FETCH:  supply_sel_o = SUP_PROG;
            ST_SETUP: begin
                supply_sel_o   = SUP_PROG;
                tgt_wdata_en_o = 1'b1;
            end
            ST_PULSE: begin
                supply_sel_o   = SUP_PROG;
                tgt_wdata_en_o = 1'b1;
                tgt_ce_n_o     = 1'b0;
            end
            ST_HOLD: begin
                supply_sel_o   = SUP_PROG;
                tgt_wdata_en_o = 1'b1;
            end
            ST_TURN:   supply_sel_o = SUP_PROG;
            ST_VERIFY: begin
                supply_sel_o = SUP_PROG;
                tgt_oe_n_o   = 1'b0;
            end
            ST_CSET:   supply_sel_o = pass2_q ? SUP_VLO : SUP_VHI;
            ST_CREAD: begin
                supply_sel_o = pass2_q ? SUP_VLO : SUP_VHI;
                tgt_oe_n_o   = 1'b0;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign tgt_addr_o  = addr_q;
    assign src_addr_o  = addr_q;
    assign tgt_wdata_o = din_q;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign fail_addr_o = fail_addr_q;

    // Pulse length monitor counter
    logic [TW-1:0] pw_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_cnt <= '0;
        end else if (!tgt_ce_n_o) begin
            pw_cnt <= pw_cnt + 1'b1;
        end else begin
            pw_cnt <= '0;
        end
    end

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_ce_n_o) |-> (pw_cnt == TW'(PULSE_CYC)));

    // R9
    pulse_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_ce_n_o |-> (supply_sel_o == SUP_PROG && tgt_wdata_en_o && tgt_oe_n_o));

    // R5
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_oe_n_o |-> !tgt_wdata_en_o);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(start_i && !busy_o)) |=> done_o);

    // R10
    fail_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !(start_i && !busy_o)) |=> (fail_o && $stable(fail_addr_o)));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (first_q == $past(first_q) && last_q == $past(last_q)));

    // R9
    idle_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (supply_sel_o == SUP_OFF));

endmodule

// File: tb/test_word_burn_seq.sv
`timescale 1ns/1ps
module test_word_burn_seq;

    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int CPU   = 2;
    localparam int RDD   = 3;
    localparam int SETC  = 2 * CPU;
    localparam int PULC  = 50 * CPU;
    localparam int HOLDC = 2 * CPU;
    localparam int NV    = 6;

    typedef struct packed {
        logic [15:0] first;
        logic [15:0] last;
        logic [15:0] need;
        logic [15:0] sp_addr;
        logic [15:0] sp_need;
        logic [15:0] weak_addr;
        logic [15:0] weak_mode;
        logic [15:0] exp_fail;
        logic [15:0] exp_faddr;
        logic [15:0] exp_pg;
        logic [15:0] exp_hi;
        logic [15:0] exp_lo;
    } vec_t;

    // weak_mode: 0 none, 1 bad at low verify level, 2 bad at both verify levels
    localparam vec_t VECS [NV] = '{
        '{16'd0,  16'd3,  16'd1, 16'd255, 16'd1,  16'd255, 16'd0, 16'd0, 16'd0,  16'd4,  16'd4, 16'd4},
        '{16'd5,  16'd5,  16'd3, 16'd255, 16'd1,  16'd255, 16'd0, 16'd0, 16'd0,  16'd3,  16'd1, 16'd1},
        '{16'd8,  16'd10, 16'd2, 16'd9,   16'd25, 16'd255, 16'd0, 16'd0, 16'd0,  16'd29, 16'd3, 16'd3},
        '{16'd16, 16'd18, 16'd1, 16'd17,  16'd26, 16'd255, 16'd0, 16'd1, 16'd17, 16'd26, 16'd0, 16'd0},
        '{16'd20, 16'd22, 16'd1, 16'd255, 16'd1,  16'd21,  16'd1, 16'd1, 16'd21, 16'd3,  16'd3, 16'd2},
        '{16'd24, 16'd26, 16'd2, 16'd255, 16'd1,  16'd25,  16'd2, 16'd1, 16'd25, 16'd6,  16'd2, 16'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] first_addr_i = '0;
    logic [AW-1:0] last_addr_i = '0;
    logic [AW-1:0] src_addr_o, tgt_addr_o, fail_addr_o;
    logic [DW-1:0] src_data_i, tgt_wdata_o, tgt_rdata_i;
    logic          tgt_wdata_en_o, tgt_ce_n_o, tgt_oe_n_o;
    logic [1:0]    supply_sel_o;
    logic          busy_o, done_o, fail_o;

    always #2 clk = ~clk;

    word_burn_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PER_US(CPU), .PULSE_US(50),
        .SETUP_US(2), .HOLD_US(2), .MAX_PULSES(25), .RD_DLY(RDD)
    ) i_word_burn_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .first_addr_i(first_addr_i), .last_addr_i(last_addr_i),
        .src_addr_o(src_addr_o), .src_data_i(src_data_i),
        .tgt_addr_o(tgt_addr_o), .tgt_wdata_o(tgt_wdata_o),
        .tgt_wdata_en_o(tgt_wdata_en_o), .tgt_rdata_i(tgt_rdata_i),
        .tgt_ce_n_o(tgt_ce_n_o), .tgt_oe_n_o(tgt_oe_n_o),
        .supply_sel_o(supply_sel_o), .busy_o(busy_o), .done_o(done_o),
        .fail_o(fail_o), .fail_addr_o(fail_addr_o)
    );

    // Target array model
    logic [DW-1:0] mem  [256];
    int            pcnt [256];
    int            m_need, m_sp_addr, m_sp_need, m_weak_addr, m_weak_mode;

    function automatic logic [DW-1:0] src_fn(input logic [AW-1:0] a);
        return (16'hA5C0 ^ {a, a}) & 16'hFFFE;
    endfunction

    assign src_data_i = src_fn(src_addr_o);

    logic weak_now;
    assign weak_now = (int'(tgt_addr_o) == m_weak_addr) &&
                      ((m_weak_mode == 1 && supply_sel_o == 2'd3) ||
                       (m_weak_mode == 2 && supply_sel_o >= 2'd2));
    assign tgt_rdata_i = (!tgt_oe_n_o && tgt_ce_n_o) ?
                         (mem[tgt_addr_o] | (weak_now ? 16'h0001 : 16'h0000)) : 16'hFFFF;

    // Monitor
    int errors = 0, checks = 0;
    int n_pg, n_rd1, n_rd2, n_rd3;
    int v_setup, v_width, v_hold, v_gap, v_cont, v_sup, v_pwr, v_idle;
    int age_d, hold_age, sup_age, pw;
    logic [AW+DW:0] ch_prev;
    logic ce_prev, oe_prev;
    logic [1:0] sup_prev;
    bit finished = 0;

    task automatic clear_counts();
        n_pg = 0; n_rd1 = 0; n_rd2 = 0; n_rd3 = 0;
        v_setup = 0; v_width = 0; v_hold = 0; v_gap = 0;
        v_cont = 0; v_sup = 0; v_pwr = 0; v_idle = 0;
    endtask

    initial begin
        clear_counts();
        age_d = 1000; hold_age = 1000; sup_age = 1000; pw = 0;
        ch_prev = '0; ce_prev = 1'b1; oe_prev = 1'b1; sup_prev = 2'd0;
        for (int i = 0; i < 256; i++) begin
            mem[i] = '1;
            pcnt[i] = 0;
        end
        m_need = 1; m_sp_addr = 999; m_sp_need = 1; m_weak_addr = 999; m_weak_mode = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [AW+DW:0] ch;
            ch = {tgt_addr_o, tgt_wdata_o, tgt_wdata_en_o};
            if (age_d < 1000) age_d++;
            if (hold_age < 1000) hold_age++;
            if (sup_age < 1000) sup_age++;
            if (supply_sel_o != sup_prev) sup_age = 0;
            if (ch != ch_prev) begin
                if (hold_age < HOLDC) v_hold++;
                if (tgt_addr_o != ch_prev[AW+DW:DW+1] && supply_sel_o == 2'd1 && sup_age < SETC)
                    v_pwr++;
                age_d = 0;
            end
            if (!tgt_ce_n_o) pw++;
            if (ce_prev && !tgt_ce_n_o) begin
                n_pg++;
                if (age_d < SETC || tgt_oe_n_o == 1'b0) v_setup++;
                pcnt[tgt_addr_o]++;
                if (pcnt[tgt_addr_o] >= ((int'(tgt_addr_o) == m_sp_addr) ? m_sp_need : m_need))
                    mem[tgt_addr_o] = mem[tgt_addr_o] & tgt_wdata_o;
            end
            if (!ce_prev && tgt_ce_n_o) begin
                if (pw != PULC) v_width++;
                pw = 0;
                hold_age = 0;
            end
            if (oe_prev && !tgt_oe_n_o) begin
                if (age_d < SETC) v_gap++;
                case (supply_sel_o)
                    2'd1: n_rd1++;
                    2'd2: n_rd2++;
                    2'd3: n_rd3++;
                    default: ;
                endcase
            end
            if (tgt_wdata_en_o && !tgt_oe_n_o) v_cont++;
            if (!tgt_ce_n_o && supply_sel_o != 2'd1) v_sup++;
            if (!busy_o && supply_sel_o != 2'd0) v_idle++;
            ch_prev = ch; ce_prev = tgt_ce_n_o; oe_prev = tgt_oe_n_o; sup_prev = supply_sel_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    task automatic run_case(input int idx);
        vec_t v;
        int wait_cyc;
        v = VECS[idx];
        for (int i = 0; i < 256; i++) begin
            mem[i] = '1;
            pcnt[i] = 0;
        end
        m_need = int'(v.need); m_sp_addr = int'(v.sp_addr); m_sp_need = int'(v.sp_need);
        m_weak_addr = int'(v.weak_addr); m_weak_mode = int'(v.weak_mode);
        clear_counts();
        first_addr_i = v.first[AW-1:0];
        last_addr_i  = v.last[AW-1:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2, R10: start taken, flags cleared
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        check(done_o == 1'b0 && fail_o == 1'b0, "R10 flags cleared by start",
              {done_o, fail_o}, 0);
        if (idx == 0) begin
            repeat (300) @(negedge clk);
            first_addr_i = 8'd40;
            last_addr_i  = 8'd41;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            // R2: start while busy ignored
            check(busy_o == 1'b1 && done_o == 1'b0, "R2 start ignored while busy", busy_o, 1);
            check(pcnt[40] == 0, "R2 no pulse at ignored range", pcnt[40], 0);
        end
        wait_cyc = 0;
        while (!done_o && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(done_o == 1'b1, $sformatf("R10 done case %0d", idx), done_o, 1);
        check(busy_o == 1'b0, $sformatf("R10 busy clear case %0d", idx), busy_o, 0);
        check(fail_o == v.exp_fail[0], $sformatf("R7 R8 fail flag case %0d", idx),
              fail_o, int'(v.exp_fail));
        if (v.exp_fail[0])
            check(fail_addr_o == v.exp_faddr[AW-1:0], $sformatf("R10 fail address case %0d", idx),
                  fail_addr_o, int'(v.exp_faddr));
        check(n_pg == int'(v.exp_pg), $sformatf("R6 R7 pulse count case %0d", idx),
              n_pg, int'(v.exp_pg));
        check(n_rd1 == int'(v.exp_pg), $sformatf("R5 per-word verifies case %0d", idx),
              n_rd1, int'(v.exp_pg));
        check(n_rd2 == int'(v.exp_hi), $sformatf("R8 high-level reads case %0d", idx),
              n_rd2, int'(v.exp_hi));
        check(n_rd3 == int'(v.exp_lo), $sformatf("R8 low-level reads case %0d", idx),
              n_rd3, int'(v.exp_lo));
        check(v_setup == 0 && v_width == 0 && v_hold == 0,
              $sformatf("R4 pulse timing case %0d", idx), v_setup + v_width + v_hold, 0);
        check(v_gap == 0 && v_cont == 0, $sformatf("R5 turnaround case %0d", idx),
              v_gap + v_cont, 0);
        check(v_pwr == 0, $sformatf("R3 power-up window case %0d", idx), v_pwr, 0);
        check(v_sup == 0 && v_idle == 0, $sformatf("R9 supply levels case %0d", idx),
              v_sup + v_idle, 0);
        // R10: sticky flags
        repeat (25) @(negedge clk);
        check(done_o == 1'b1 && fail_o == v.exp_fail[0], $sformatf("R10 sticky case %0d", idx),
              {done_o, fail_o}, {1'b1, v.exp_fail[0]});
        if (v.exp_fail[0])
            check(fail_addr_o == v.exp_faddr[AW-1:0], $sformatf("R10 address held case %0d", idx),
                  fail_addr_o, int'(v.exp_faddr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tgt_ce_n_o && tgt_oe_n_o && !tgt_wdata_en_o, "R1 bus idle in reset",
              {tgt_ce_n_o, tgt_oe_n_o, tgt_wdata_en_o}, 3'b110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(supply_sel_o == 2'd0, "R1 supply off after reset", supply_sel_o, 0);
        check(!busy_o && !done_o && !fail_o, "R1 status after reset",
              {busy_o, done_o, fail_o}, 0);
        check(tgt_ce_n_o && tgt_oe_n_o && !tgt_wdata_en_o, "R1 bus idle after reset",
              {tgt_ce_n_o, tgt_oe_n_o, tgt_wdata_en_o}, 3'b110);
        for (int k = 0; k < NV; k++) begin
            run_case(k);
        end
        // R9: idle after last run
        check(supply_sel_o == 2'd0, "R9 supply off when idle", supply_sel_o, 0);
        finish_run();
    end

endmodule